// File: doc/BRIEF.md
# Saturating Rounded Fixed-Point Multiplier

This block multiplies two signed fixed-point operands. Each operand has 8 bits in total, and the 3 least significant bits are fractional. The result is an 8-bit value in the same format. The block forms the exact double-width product first. It then adds half of one result LSB and shifts right arithmetically to return to the operand scale, so ties round toward positive infinity. Any value outside the signed 8-bit range is clamped to the nearest limit. A flag reports when clamping took place.

The block suits the coefficient-times-state terms of a small fixed-point control loop, where wrap-around on overflow would cause a sign flip and must not happen. One parameter selects one of two variants. In the first, a single output register stage holds the result and flag, and a synchronous active-high reset clears them. In the second, the path is purely combinational.

Top module: `qfix_mul`

The datapath has no state machine. The only state is the optional output register, which is either cleared by reset or loaded on each clock.

## Requirements
- R1: Both operands are sign-extended to twice the data width before they are multiplied, so the intermediate product is exact for every operand pair, including (-128)x(-128) = 16384.
- R2: If either operand is zero, the result is 0 and the flag is low.
- R3: Rounding adds 2^(F-1), with F = 3, to the raw product and then shifts it right arithmetically by F bits. A product of exactly -0.5 result LSB (raw -4) gives 0. A raw product of +4 gives 1. A raw product of -12 gives -1.
- R4: A scaled value above +127 gives +127 (0x7F), and a scaled value below -128 gives -128 (0x80). In both cases sat_out is high.
- R5: A scaled value within [-128, +127] appears unchanged as its low 8 bits, and sat_out is low.
- R6: When OUT_REG = 1 (the default), y_out and sat_out reflect the operands present at the previous rising clock edge.
- R7: When rst is high at a rising edge, y_out becomes 0 and sat_out becomes 0 after that edge.
- R8: (-128)x(-128) gives +127 with sat_out high.
- R9: Multiplying by 1.0 (operand code 0x08) returns the other operand unchanged, with sat_out low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the optional output register |
| rst | input | 1 | Synchronous active-high reset of the output register |
| a_in | input | 8 | Operand A, signed, 3 fractional bits |
| b_in | input | 8 | Operand B, signed, 3 fractional bits |
| y_out | output | 8 | Rounded and clamped product, signed, 3 fractional bits |
| sat_out | output | 1 | High when the result was clamped |

## Verification
The assertions assume the default registered variant. They also assume the operands are two-state values that change only away from the rising edge, so each `$past` of an operand is the value that the output register captured. The bench drives a_in and b_in on falling edges only and holds them through the following rising edge. It mixes directed corner pairs with seeded random pairs drawn over the full signed 8-bit range. The random pairs therefore reach both clamp limits and the half-LSB ties without leaving the domain the assertions assume.

// File: rtl/qmul_pkg.sv
package qmul_pkg;
    localparam int QM_DATA_W = 8;
    localparam int QM_FRAC_W = 3;
    localparam int QM_PROD_W = 2 * QM_DATA_W;
endpackage

// File: rtl/qmul_widen_mult.sv
module qmul_widen_mult #(
    parameter int W = 8
) (
    input  logic signed [W-1:0]   op_a,
    input  logic signed [W-1:0]   op_b,
    output logic signed [2*W-1:0] prod
);
    localparam int PW = 2 * W;

    logic signed [PW-1:0] wide_a;
    logic signed [PW-1:0] wide_b;

    always_comb begin
        wide_a = {{W{op_a[W-1]}}, op_a};
        wide_b = {{W{op_b[W-1]}}, op_b};
        prod   = wide_a * wide_b;
    end
endmodule

// File: rtl/qmul_round_scale.sv
module qmul_round_scale #(
    parameter int PW = 16,
    parameter int F  = 3
) (
    input  logic signed [PW-1:0] prod,
    output logic signed [PW-1:0] scaled
);
    generate
        if (F == 0) begin : g_noscale
            assign scaled = prod;
        end else begin : g_scale
            localparam logic signed [PW-1:0] HALF_LSB = PW'(1) << (F - 1);
            logic signed [PW-1:0] biased;
            always_comb begin
                biased = prod + HALF_LSB;
                scaled = biased >>> F;
            end
        end
    endgenerate
endmodule

// File: rtl/qmul_clamp.sv
module qmul_clamp #(
    parameter int PW = 16,
    parameter int W  = 8
) (
    input  logic signed [PW-1:0] scaled,
    output logic signed [W-1:0]  res,
    output logic                 clipped
);
    localparam logic signed [PW-1:0] TOP_V = {{(PW-W+1){1'b0}}, {(W-1){1'b1}}};
    localparam logic signed [PW-1:0] BOT_V = {{(PW-W+1){1'b1}}, {(W-1){1'b0}}};

    always_comb begin
        if (scaled > TOP_V) begin
            res     = {1'b0, {(W-1){1'b1}}};
            clipped = 1'b1;
        end else if (scaled < BOT_V) begin
            res     = {1'b1, {(W-1){1'b0}}};
            clipped = 1'b1;
        end else begin
            res     = scaled[W-1:0];
            clipped = 1'b0;
        end
    end
endmodule

// File: rtl/qfix_mul.sv
module qfix_mul
    import qmul_pkg::*;
#(
    parameter int DATA_W  = QM_DATA_W,
    parameter int FRAC_W  = QM_FRAC_W,
    parameter bit OUT_REG = 1'b1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DATA_W-1:0] a_in,
    input  logic signed [DATA_W-1:0] b_in,
    output logic signed [DATA_W-1:0] y_out,
    output logic                     sat_out
);
    localparam int PROD_W = 2 * DATA_W;

    logic signed [PROD_W-1:0] prod_full;
    logic signed [PROD_W-1:0] prod_scaled;
    logic signed [DATA_W-1:0] y_next;
    logic                     sat_next;

    qmul_widen_mult #(.W(DATA_W)) u_mult (
        .op_a (a_in),
        .op_b (b_in),
        .prod (prod_full)
    );

    qmul_round_scale #(.PW(PROD_W), .F(FRAC_W)) u_round (
        .prod   (prod_full),
        .scaled (prod_scaled)
    );

    qmul_clamp #(.PW(PROD_W), .W(DATA_W)) u_clamp (
        .scaled  (prod_scaled),
        .res     (y_next),
        .clipped (sat_next)
    );

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    y_out   <= '0;
                    sat_out <= 1'b0;
                end else begin
                    y_out   <= y_next;
                    sat_out <= sat_next;
                end
            end
        end else begin : g_comb
            assign y_out   = y_next;
            assign sat_out = sat_next;
        end
    endgenerate
endmodule

// File: rtl/qfix_mul_chk.sv
module qfix_mul_chk #(
    parameter int W       = 8,
    parameter bit OUT_REG = 1'b1
) (
    input logic                clk,
    input logic                rst,
    input logic signed [W-1:0] a,
    input logic signed [W-1:0] b,
    input logic signed [W-1:0] y,
    input logic                sat
);
    localparam logic signed [W-1:0] TOP_C = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] BOT_C = {1'b1, {(W-1){1'b0}}};
    localparam logic signed [W-1:0] ONE_C = W'(8);

    generate
        if (OUT_REG) begin : g_chk
            AST_RESET_CLEAR: assert property (@(posedge clk) rst |=> (y == '0 && !sat)); // R7
            AST_SAT_AT_LIMIT: assert property (@(posedge clk) disable iff (rst)
                sat |-> (y == TOP_C || y == BOT_C)); // R4
            AST_SAT_SIGN: assert property (@(posedge clk) disable iff (rst)
                (sat && ($past(a[W-1]) == $past(b[W-1]))) |-> (y == TOP_C)); // R8
            AST_ZERO_OPERAND: assert property (@(posedge clk) disable iff (rst)
                (a == '0 || b == '0) |=> (y == '0 && !sat)); // R2
            AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (rst)
                (b == ONE_C) |=> (y == $past(a) && !sat)); // R9
        end else begin : g_none
            always_comb begin
                AST_SAT_AT_LIMIT_C: assert (!sat || y == TOP_C || y == BOT_C); // R4
            end
        end
    endgenerate
endmodule

bind qfix_mul qfix_mul_chk #(.W(DATA_W), .OUT_REG(OUT_REG)) u_chk (
    .clk (clk),
    .rst (rst),
    .a   (a_in),
    .b   (b_in),
    .y   (y_out),
    .sat (sat_out)
);

// File: tb/test_qfix_mul.sv
module test_qfix_mul;
    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic signed [7:0] a_in = '0;
    logic signed [7:0] b_in = '0;
    logic signed [7:0] y_out;
    logic              sat_out;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    qfix_mul i_qfix_mul (
        .clk     (clk),
        .rst     (rst),
        .a_in    (a_in),
        .b_in    (b_in),
        .y_out   (y_out),
        .sat_out (sat_out)
    );

    function automatic int floor_div8(input int v);
        if (v >= 0) return v / 8;
        return -((-v + 7) / 8);
    endfunction

    function automatic int model_val(input int a, input int b);
        int s;
        s = floor_div8(a * b + 4);
        if (s > 127) return 127;
        if (s < -128) return -128;
        return s;
    endfunction

    function automatic bit model_sat(input int a, input int b);
        int s;
        s = floor_div8(a * b + 4);
        return (s > 127) || (s < -128);
    endfunction

    task automatic check(input string req, input int got_y, input bit got_s,
                         input int exp_y, input bit exp_s);
        n_checks++;
        if (got_y != exp_y || got_s != exp_s) begin
            n_fails++;
            $display("FAIL %s: y=%0d sat=%0b expected y=%0d sat=%0b",
                     req, got_y, got_s, exp_y, exp_s);
        end
    endtask

    task automatic apply(input int a, input int b, input string req);
        @(negedge clk);
        a_in = 8'(a);
        b_in = 8'(b);
        @(negedge clk);
        check(req, int'(y_out), sat_out, model_val(a, b), model_sat(a, b));
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R7 reset state", int'(y_out), sat_out, 0, 1'b0);
        rst = 1'b0;

        apply(-128, -128, "R8 most negative squared");
        apply(-128, -128, "R1 exact wide product");
        apply(0, 93, "R2 zero operand A");
        apply(-77, 0, "R2 zero operand B");
        apply(-1, 4, "R3 tie -0.5 LSB to zero");
        apply(1, 4, "R3 tie +0.5 LSB up");
        apply(-3, 4, "R3 tie -1.5 LSB");
        apply(-1, 5, "R3 below tie");
        apply(127, 127, "R4 positive clamp");
        apply(-128, 127, "R4 negative clamp");
        apply(64, 16, "R4 just above top");
        apply(35, 29, "R5 in range");
        apply(-40, 25, "R5 in range negative");
        apply(-113, 8, "R9 unity gain");
        apply(8, 127, "R9 unity gain A");
        apply(-128, 8, "R9 unity gain min");

        // R6: output holds the registered result of the previous operands
        @(negedge clk);
        a_in = 8'sd16; b_in = 8'sd24;
        @(posedge clk);
        #1;
        check("R6 one-cycle latency", int'(y_out), sat_out, 48, 1'b0);

        for (int i = 0; i < 3000; i++) begin
            int ra;
            int rb;
            ra = int'($signed(8'($urandom)));
            rb = int'($signed(8'($urandom)));
            apply(ra, rb, "R5 random pair");
        end

        // R7: reset mid-run clears the output
        @(negedge clk);
        a_in = 8'sd127; b_in = 8'sd127; rst = 1'b1;
        @(negedge clk);
        check("R7 reset mid-run", int'(y_out), sat_out, 0, 1'b0);
        rst = 1'b0;
        @(negedge clk);
        check("R4 after reset release", int'(y_out), sat_out, 127, 1'b1);

        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_checks++;
                n_fails++;
                $display("FAIL watchdog: y=%0d expected completion", y_out);
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule